// File: doc/BRIEF.md
# Buck Skip-Mode Entry Controller

This block is the digital part of a step-down converter channel that selects the operating mode. One mode is normal fixed-frequency PWM. The other is pulse-skipping for light loads. The block does not see analog quantities. It reads a set of comparator flags on every system clock:
- a per-cycle zero-crossing flag for the inductor current,
- a flag that the high-side current has reached its skip-pulse level, about a fifth of the peak limit,
- a peak-current-limit flag,
- three output-voltage window flags: 1.5 % above nominal, at or below nominal, and more than 1.5 % below nominal.

The block receives the PWM clock as a plain input and detects its rising edges. Each rising edge marks the start of a switching cycle, called a tick. The zero-crossing and output-low flags are evaluated only on ticks. The current and over-voltage flags act on any system clock.

In PWM mode, the high-side switch turns on at each tick and turns off when the external modulator raises its off event. After a run of consecutive cycles with a zero crossing, the block moves to skip mode. In skip mode, pulses still start on ticks but end at the skip current level. Bursts pause when the output climbs above the upper threshold and resume once the output is back at nominal. A low output returns the channel to PWM. A mode-select input can force PWM at any time.

Top module: `skip_entry_ctrl`

## Requirements
- R1: After reset `skipMode` is 0 (0 = PWM, 1 = skip) and `hsOn` is 0. With `modeAuto`=1, `skipMode` goes to 1 on the tick that completes 16 consecutive ticks sampled with `zeroCross`=1, and not earlier.
- R2: Any tick sampled with `zeroCross`=0 clears the consecutive-cycle count, so a further 16 crossing ticks are needed to enter skip mode.
- R3: With `modeAuto`=0 the block never enters skip mode, however many crossing ticks occur.
- R4: Setting `modeAuto` to 0 while in skip mode returns `skipMode` to 0 on the next clock edge, without waiting for a tick, and clears the count.
- R5: A high-side pulse starts (`hsOn` 1 on the next clock edge) only on a tick, which is a rising edge of `pwmClk` seen as `pwmClk`=1 where the previous sample was 0. A `pwmClk` held high gives one tick. Between ticks `hsOn` holds its value.
- R6: In skip mode, `curSkipLim`=1 clears `hsOn` on the next clock edge.
- R7: In skip mode, `outHigh`=1 clears `hsOn` on the next edge and pauses bursting. Ticks then start no pulse until `outAtNom`=1 has been seen. After that, the next tick starts a pulse again.
- R8: In skip mode, a tick sampled with `outLow`=1 returns `skipMode` to 0 and starts a pulse on that tick. `outLow` between ticks has no effect.
- R9: In PWM mode, `pwmOff`=1 clears `hsOn` on the next edge. In PWM mode, `curSkipLim` and `outHigh` do not affect `hsOn`.
- R10: `peakLim`=1 clears `hsOn` on the next clock edge in either mode, even on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmClk | input | 1 | PWM clock; its rising edge marks a switching cycle |
| modeAuto | input | 1 | 1 = automatic skip/PWM, 0 = forced PWM |
| zeroCross | input | 1 | Inductor current crossed zero in this cycle |
| curSkipLim | input | 1 | High-side current at the skip-pulse level |
| peakLim | input | 1 | High-side current at the peak limit |
| outHigh | input | 1 | Output above nominal by 1.5 % |
| outAtNom | input | 1 | Output at or below nominal |
| outLow | input | 1 | Output below nominal by more than 1.5 % |
| pwmOff | input | 1 | Off event from the PWM modulator |
| hsOn | output | 1 | High-side switch enable |
| skipMode | output | 1 | Current mode, 1 = skip |

## Verification
The entry count is swept as follows. For every break position from 1 to 15, a run of crossing ticks is interrupted by one non-crossing tick. Then 15 more crossing ticks must leave the block in PWM, and a 16th must switch it to skip. This separates a counter that resets from one that merely pauses or that is off by one.

A `pwmClk` held high across several system clocks tells edge detection apart from level sampling. Forced-PWM runs show that the mode bit blocks entry.

In skip mode, separate patterns drive the skip current level, the over-voltage pause, and the resume at nominal. Another pattern applies `outLow` on and off ticks. These tell the skip-mode pulse rules apart from the PWM ones. The same flags are then repeated in PWM mode, where only the modulator off event and the peak limit may end a pulse.

// File: rtl/skip_entry_pkg.sv
package skip_entry_pkg;
  typedef enum logic {
    MODE_PWM  = 1'b0,
    MODE_SKIP = 1'b1
  } mode_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic cntInc;      // count one more crossing cycle
    logic cntClr;      // clear the crossing count (wins over cntInc)
    logic pulseStart;  // turn the high-side switch on
    logic pulseStop;   // turn the high-side switch off (wins over start)
  } strobe_t;
endpackage

// File: rtl/skip_datapath.sv
module skip_datapath
  import skip_entry_pkg::*;
#(
  parameter int ZC_RUN = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    pwmClk,
  input  strobe_t strb,
  output logic    tick,
  output logic    runDone,
  output logic    hsOn
);
  localparam int CNT_W = $clog2(ZC_RUN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ZC_RUN - 1);

  logic             pwmClkQ;
  logic [CNT_W-1:0] zcCount;

  assign tick    = pwmClk && !pwmClkQ;
  assign runDone = strb.cntInc && (zcCount == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwmClkQ <= 1'b0;
    else       pwmClkQ <= pwmClk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            zcCount <= '0;
    else if (strb.cntClr) zcCount <= '0;
    else if (strb.cntInc) zcCount <= zcCount + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                hsOn <= 1'b0;
    else if (strb.pulseStop)  hsOn <= 1'b0;
    else if (strb.pulseStart) hsOn <= 1'b1;
  end
endmodule

// File: rtl/skip_control.sv
module skip_control
  import skip_entry_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    runDone,
  input  logic    modeAuto,
  input  logic    zeroCross,
  input  logic    curSkipLim,
  input  logic    peakLim,
  input  logic    outHigh,
  input  logic    outAtNom,
  input  logic    outLow,
  input  logic    pwmOff,
  output strobe_t strb,
  output logic    skipMode
);
  mode_e mode;
  logic  burstOn;
  logic  inPwm;
  logic  exitSkip;

  assign inPwm    = (mode == MODE_PWM);
  assign skipMode = (mode == MODE_SKIP);

  always_comb begin
    exitSkip        = !inPwm && (!modeAuto || (tick && outLow));
    strb.cntInc     = tick && inPwm && modeAuto && zeroCross;
    strb.cntClr     = !inPwm || !modeAuto || (tick && !zeroCross) || runDone;
    strb.pulseStart = tick && (inPwm || burstOn || exitSkip);
    strb.pulseStop  = peakLim || (inPwm ? pwmOff : (curSkipLim || outHigh));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                mode <= MODE_PWM;
    else if (inPwm && runDone) mode <= MODE_SKIP;
    else if (exitSkip)         mode <= MODE_PWM;
  end

  // burst gate: active on entry, paused by over-voltage, resumed at nominal
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         burstOn <= 1'b1;
    else if (inPwm)    burstOn <= 1'b1;
    else if (outHigh)  burstOn <= 1'b0;
    else if (outAtNom) burstOn <= 1'b1;
  end
endmodule

// File: rtl/skip_entry_ctrl.sv
module skip_entry_ctrl
  import skip_entry_pkg::*;
#(
  parameter int ZC_RUN = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwmClk,
  input  logic modeAuto,
  input  logic zeroCross,
  input  logic curSkipLim,
  input  logic peakLim,
  input  logic outHigh,
  input  logic outAtNom,
  input  logic outLow,
  input  logic pwmOff,
  output logic hsOn,
  output logic skipMode
);
  strobe_t strb;
  logic    tick;
  logic    runDone;

  skip_datapath #(.ZC_RUN(ZC_RUN)) u_dp (
    .clk(clk), .rstN(rstN), .pwmClk(pwmClk), .strb(strb),
    .tick(tick), .runDone(runDone), .hsOn(hsOn)
  );

  skip_control u_ctl (
    .clk(clk), .rstN(rstN), .tick(tick), .runDone(runDone),
    .modeAuto(modeAuto), .zeroCross(zeroCross), .curSkipLim(curSkipLim),
    .peakLim(peakLim), .outHigh(outHigh), .outAtNom(outAtNom),
    .outLow(outLow), .pwmOff(pwmOff), .strb(strb), .skipMode(skipMode)
  );
endmodule

// File: rtl/skip_entry_chk.sv
module skip_entry_chk (
  input logic clk,
  input logic rstN,
  input logic pwmClk,
  input logic modeAuto,
  input logic zeroCross,
  input logic curSkipLim,
  input logic peakLim,
  input logic outHigh,
  input logic outLow,
  input logic hsOn,
  input logic skipMode
);
  // R10
  peak_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    peakLim |=> !hsOn);
  // R1
  entry_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(skipMode) |-> ($past(pwmClk) && $past(zeroCross) && $past(modeAuto)));
  // R4
  forced_pwm_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeAuto |=> !skipMode);
  // R5
  start_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsOn) |-> $past(pwmClk));
  // R6
  skip_cur_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (skipMode && curSkipLim) |=> !hsOn);
  // R7
  skip_ovp_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (skipMode && outHigh) |=> !hsOn);
  // R8
  exit_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(skipMode) |-> (!$past(modeAuto) || ($past(outLow) && $past(pwmClk))));
endmodule

bind skip_entry_ctrl skip_entry_chk u_chk (
  .clk(clk), .rstN(rstN), .pwmClk(pwmClk), .modeAuto(modeAuto),
  .zeroCross(zeroCross), .curSkipLim(curSkipLim), .peakLim(peakLim),
  .outHigh(outHigh), .outLow(outLow), .hsOn(hsOn), .skipMode(skipMode)
);

// File: tb/sim_skip_entry_ctrl.sv
module sim_skip_entry_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RUN = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwmClk = 1'b0, modeAuto = 1'b1, zeroCross = 1'b0, curSkipLim = 1'b0;
  logic peakLim = 1'b0, outHigh = 1'b0, outAtNom = 1'b0, outLow = 1'b0, pwmOff = 1'b0;
  logic hsOn, skipMode;
  int   nRun = 0, nFail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  skip_entry_ctrl #(.ZC_RUN(RUN)) u0 (
    .clk(clk), .rstN(rstN), .pwmClk(pwmClk), .modeAuto(modeAuto),
    .zeroCross(zeroCross), .curSkipLim(curSkipLim), .peakLim(peakLim),
    .outHigh(outHigh), .outAtNom(outAtNom), .outLow(outLow), .pwmOff(pwmOff),
    .hsOn(hsOn), .skipMode(skipMode)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one switching cycle: pwmClk high one clock, then low
  task automatic tick(input logic zc);
    @(negedge clk); pwmClk = 1'b1; zeroCross = zc;
    @(negedge clk); pwmClk = 1'b0; zeroCross = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic backToPwm();
    @(negedge clk); modeAuto = 1'b0;
    @(negedge clk); modeAuto = 1'b1;
  endtask

  task automatic enterSkip();
    backToPwm();
    for (int i = 0; i < RUN; i++) tick(1'b1);
  endtask

  initial begin
    #(200000 * CLK_PERIOD);
    if (!done) begin
      nFail++; nRun++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset skipMode", skipMode, 1'b0);
    check("R1 reset hsOn", hsOn, 1'b0);
    rstN = 1'b1;

    // R1: exactly RUN crossing ticks
    for (int i = 0; i < RUN - 1; i++) tick(1'b1);
    check("R1 after 15 ticks", skipMode, 1'b0);
    tick(1'b1);
    check("R1 after 16 ticks", skipMode, 1'b1);

    // R2: sweep of the break position
    for (int k = 1; k < RUN; k++) begin
      backToPwm();
      for (int i = 0; i < k; i++) tick(1'b1);
      check("R2 before break", skipMode, 1'b0);
      tick(1'b0);
      for (int i = 0; i < RUN - 1; i++) tick(1'b1);
      check("R2 15 after break", skipMode, 1'b0);
      tick(1'b1);
      check("R2 16 after break", skipMode, 1'b1);
    end

    // R5: held-high pwmClk counts once
    backToPwm();
    for (int i = 0; i < RUN - 2; i++) tick(1'b1);
    @(negedge clk); pwmClk = 1'b1; zeroCross = 1'b1;
    repeat (6) @(negedge clk);
    pwmClk = 1'b0; zeroCross = 1'b0;
    @(negedge clk);
    check("R5 held high counted once", skipMode, 1'b0);
    tick(1'b1);
    check("R5 next edge completes run", skipMode, 1'b1);

    // R3: forced PWM blocks entry
    @(negedge clk); modeAuto = 1'b0;
    for (int i = 0; i < RUN + 4; i++) tick(1'b1);
    check("R3 forced PWM no entry", skipMode, 1'b0);
    modeAuto = 1'b1;

    // R4: forced exit from skip, no tick needed, count cleared
    enterSkip();
    check("R4 in skip", skipMode, 1'b1);
    @(negedge clk); modeAuto = 1'b0;
    @(negedge clk);
    check("R4 exit next edge", skipMode, 1'b0);
    modeAuto = 1'b1;
    for (int i = 0; i < RUN - 1; i++) tick(1'b1);
    check("R4 count cleared", skipMode, 1'b0);
    tick(1'b1);
    check("R4 re-entry", skipMode, 1'b1);

    // R6 / R5 in skip
    check("R5 entry tick starts pulse", hsOn, 1'b1);
    pulse(curSkipLim);
    check("R6 skip level ends pulse", hsOn, 1'b0);
    repeat (3) @(negedge clk);
    check("R5 no start between ticks", hsOn, 1'b0);
    tick(1'b0);
    check("R5 skip pulse on tick", hsOn, 1'b1);
    check("R5 still skip", skipMode, 1'b1);

    // R7: pause and resume
    pulse(outHigh);
    check("R7 over-voltage off", hsOn, 1'b0);
    tick(1'b0);
    tick(1'b0);
    check("R7 paused no pulse", hsOn, 1'b0);
    check("R7 paused still skip", skipMode, 1'b1);
    pulse(outAtNom);
    check("R7 no pulse before tick", hsOn, 1'b0);
    tick(1'b0);
    check("R7 resumed pulse", hsOn, 1'b1);

    // R8: output low
    pulse(curSkipLim);
    pulse(outLow);
    check("R8 outLow off tick ignored", skipMode, 1'b1);
    @(negedge clk); outLow = 1'b1; pwmClk = 1'b1;
    @(negedge clk); outLow = 1'b0; pwmClk = 1'b0;
    check("R8 exit on tick", skipMode, 1'b0);
    check("R8 pulse on exit tick", hsOn, 1'b1);

    // R9: PWM pulse rules
    pulse(curSkipLim);
    check("R9 skip level ignored in PWM", hsOn, 1'b1);
    pulse(outHigh);
    check("R9 over-voltage ignored in PWM", hsOn, 1'b1);
    pulse(pwmOff);
    check("R9 modulator off", hsOn, 1'b0);
    tick(1'b0);
    check("R9 PWM tick starts pulse", hsOn, 1'b1);

    // R10: peak limit in both modes
    pulse(peakLim);
    check("R10 peak in PWM", hsOn, 1'b0);
    @(negedge clk); peakLim = 1'b1; pwmClk = 1'b1;
    @(negedge clk); peakLim = 1'b0; pwmClk = 1'b0;
    check("R10 peak wins on tick", hsOn, 1'b0);
    enterSkip();
    check("R10 skip pulse on", hsOn, 1'b1);
    pulse(peakLim);
    check("R10 peak in skip", hsOn, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule